// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the address and count sequence of a data mover running in block mode. Software loads a source address, a destination address, a block size, a block count and a few mode bits. Each start pulse then moves one complete block of units. Every unit is moved as a read from the current source address followed by a write of the same data to the current destination address. Each access uses a simple request/ready handshake.

Either the source or the destination is chosen as the block area. Inside a block, the block-area address walks forward by the unit size. When the block ends, that address and the unit counter return to their values at the start of the block. The other address makes one step per block: up, down, or not at all. This gives a nested pattern, with a whole block swept again at each position of the other pointer. When the programmed number of blocks has been moved, a sticky interrupt request is raised. The sequencer then refuses further starts until it is loaded again.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `irq` are all 0.
- R2: Each unit is a read at the current source address (`mem_we`=0), then a write (`mem_we`=1) of the data returned by that read to the current destination address. A request keeps its address, direction and `mem_req` until a cycle in which `mem_ready` is 1.
- R3: `cfg_blk_src`=1 makes the source the block area, and 0 makes the destination the block area. Within a block, the block-area address advances by the unit size after each unit: 1 when `cfg_word`=0, 2 when `cfg_word`=1. At the end of the block it returns to its value at the start of the block.
- R4: The non-block address holds its value throughout a block. At the end of each block it changes according to `cfg_step_mode`: 2'b00 and 2'b11 leave it unchanged, 2'b01 adds the unit size, 2'b10 subtracts the unit size.
- R5: `cfg_bsize` gives 1 to 255 units per block, and 0 means 256. A start moves exactly that many units. One cycle after the final write is accepted, `done` pulses for one cycle and `busy` is 0.
- R6: A `start` or `cfg_load` that arrives while `busy` is 1 has no effect on the block in progress, on later addresses, or on the block count.
- R7: `cfg_bcount` gives 1 to 65535 blocks, and 0 means 65536. `irq` rises in the same cycle as the `done` of the last block, and not earlier.
- R8: `irq` stays 1 until a cycle with `irq_clr`=1, after which it is 0.
- R9: A `start` is ignored before the first `cfg_load` and after the last block, until `cfg_load` is applied again while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load all configuration while idle |
| cfg_src | input | AW | Starting source address |
| cfg_dst | input | AW | Starting destination address |
| cfg_bsize | input | SZW | Units per block (0 means 2^SZW) |
| cfg_bcount | input | CW | Number of blocks (0 means 2^CW) |
| cfg_blk_src | input | 1 | 1: source is block area, 0: destination |
| cfg_step_mode | input | 2 | Per-block step of non-block address |
| cfg_word | input | 1 | Unit size: 0 byte (1), 1 word (2) |
| start | input | 1 | Run one block |
| irq_clr | input | 1 | Clear the interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse after a block ends |
| irq | output | 1 | Sticky completion interrupt request |

## Verification
The assertions assume that the memory side answers every request in the end. They also assume that `mem_rdata` is valid whenever `mem_ready` is 1 for a read, and that `irq_clr` is only a short pulse. The bench memory model returns data computed from the address at once. It keeps ready tied to the request, or gates it with a stall that alternates every cycle. Configuration values are changed only in cycles where the bench does not pulse `cfg_load`, apart from one deliberate test of a load while busy.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_e;

    localparam logic [1:0] STEP_HOLD = 2'b00;
    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;
endpackage

// File: rtl/blk_addr_unit.sv
module blk_addr_unit
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          in_block,
    input  logic          word,
    input  logic [1:0]    step_mode,
    input  logic          unit_adv,
    input  logic          blk_end,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] base
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
    } areg_t;

    areg_t         r_q, r_d;
    logic [AW-1:0] step;

    assign step = word ? AW'(2) : AW'(1);

    always_comb begin
        r_d = r_q;
        if (ld) begin
            r_d.base = ld_val;
            r_d.cur  = ld_val;
        end else if (in_block) begin
            if (blk_end)       r_d.cur = r_q.base;
            else if (unit_adv) r_d.cur = r_q.cur + step;
        end else if (blk_end) begin
            case (step_mode)
                STEP_UP:   r_d.cur = r_q.cur + step;
                STEP_DOWN: r_d.cur = r_q.cur - step;
                default:   r_d.cur = r_q.cur;
            endcase
            r_d.base = r_d.cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur  = r_q.cur;
    assign base = r_q.base;

    // a non-block pointer never moves in the middle of a block
    assert_nonblock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !ld && !blk_end) |=> (cur == $past(cur)));
endmodule

// File: rtl/blk_count_unit.sv
module blk_count_unit #(
    parameter int SZW = 8,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [SZW-1:0] ld_bsize,
    input  logic [CW-1:0]  ld_bcount,
    input  logic           unit_done,
    output logic           last_unit,
    output logic           last_block
);
    localparam int SZC = SZW + 1;
    localparam int CC  = CW + 1;

    typedef struct packed {
        logic [SZC-1:0] reload;
        logic [SZC-1:0] left;
        logic [CC-1:0]  blocks;
    } creg_t;

    creg_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (ld) begin
            c_d.reload = (ld_bsize == '0) ? (SZC'(1) << SZW) : {1'b0, ld_bsize};
            c_d.left   = c_d.reload;
            c_d.blocks = (ld_bcount == '0) ? (CC'(1) << CW) : {1'b0, ld_bcount};
        end else if (unit_done) begin
            if (c_q.left == SZC'(1)) begin
                c_d.left   = c_q.reload;
                c_d.blocks = c_q.blocks - CC'(1);
            end else begin
                c_d.left = c_q.left - SZC'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.reload <= SZC'(1);
            c_q.left   <= SZC'(1);
            c_q.blocks <= CC'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign last_unit  = (c_q.left == SZC'(1));
    assign last_block = (c_q.blocks == CC'(1));

    assert_left_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.left != '0) && (c_q.left <= c_q.reload));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int SZW = 8,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [SZW-1:0] cfg_bsize,
    input  logic [CW-1:0]  cfg_bcount,
    input  logic           cfg_blk_src,
    input  logic [1:0]     cfg_step_mode,
    input  logic           cfg_word,
    input  logic           start,
    input  logic           irq_clr,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           busy,
    output logic           done,
    output logic           irq
);
    typedef struct packed {
        seq_state_e    state;
        logic [DW-1:0] data;
        logic          irq;
        logic          armed;
        logic          done;
        logic          blk_src;
        logic          word;
        logic [1:0]    mode;
    } ctl_t;

    ctl_t          s_q, s_d;
    logic          load_ok, unit_done, blk_end, unit_adv;
    logic          last_unit, last_block;
    logic [AW-1:0] src_cur, dst_cur, src_base, dst_base;

    assign load_ok   = cfg_load && (s_q.state == ST_IDLE);
    assign unit_done = (s_q.state == ST_WR) && mem_ready;
    assign blk_end   = unit_done && last_unit;
    assign unit_adv  = unit_done && !last_unit;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.irq  = s_q.irq && !irq_clr;
        if (load_ok) begin
            s_d.blk_src = cfg_blk_src;
            s_d.word    = cfg_word;
            s_d.mode    = cfg_step_mode;
            s_d.armed   = 1'b1;
        end
        case (s_q.state)
            ST_IDLE: begin
                if (start && s_q.armed && !cfg_load) s_d.state = ST_RD;
            end
            ST_RD: begin
                if (mem_ready) begin
                    s_d.data  = mem_rdata;
                    s_d.state = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    if (last_unit) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                        if (last_block) begin
                            s_d.irq   = 1'b1;
                            s_d.armed = 1'b0;
                        end
                    end else begin
                        s_d.state = ST_RD;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    blk_addr_unit #(.AW(AW)) u_src (
        .clk(clk), .rst_n(rst_n), .ld(load_ok), .ld_val(cfg_src),
        .in_block(s_q.blk_src), .word(s_q.word), .step_mode(s_q.mode),
        .unit_adv(unit_adv), .blk_end(blk_end), .cur(src_cur), .base(src_base)
    );

    blk_addr_unit #(.AW(AW)) u_dst (
        .clk(clk), .rst_n(rst_n), .ld(load_ok), .ld_val(cfg_dst),
        .in_block(!s_q.blk_src), .word(s_q.word), .step_mode(s_q.mode),
        .unit_adv(unit_adv), .blk_end(blk_end), .cur(dst_cur), .base(dst_base)
    );

    blk_count_unit #(.SZW(SZW), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld(load_ok), .ld_bsize(cfg_bsize),
        .ld_bcount(cfg_bcount), .unit_done(unit_done),
        .last_unit(last_unit), .last_block(last_block)
    );

    assign mem_req   = (s_q.state != ST_IDLE);
    assign mem_we    = (s_q.state == ST_WR);
    assign mem_addr  = (s_q.state == ST_WR) ? dst_cur : src_cur;
    assign mem_wdata = s_q.data;
    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign irq       = s_q.irq;

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_area_restored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (s_q.blk_src ? (src_cur == src_base) : (dst_cur == dst_base)));

    assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_no_run_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !s_q.armed) |=> !busy);
endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        bsrc;
        logic [1:0]  mode;
        logic        word;
        logic [7:0]  bsz;
        logic [15:0] bcnt;
        logic [15:0] src;
        logic [15:0] dst;
        logic        stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, 1'b0, 8'd4, 16'd3, 16'h1000, 16'h2000, 1'b0},
        '{1'b0, 2'b10, 1'b1, 8'd3, 16'd2, 16'h3000, 16'h4000, 1'b1},
        '{1'b1, 2'b00, 1'b1, 8'd1, 16'd4, 16'h0100, 16'h0200, 1'b0},
        '{1'b0, 2'b11, 1'b0, 8'd2, 16'd2, 16'h0A00, 16'h0B00, 1'b1},
        '{1'b1, 2'b10, 1'b0, 8'd0, 16'd1, 16'h2200, 16'h0001, 1'b0},
        '{1'b0, 2'b01, 1'b1, 8'd2, 16'd3, 16'hFFFE, 16'h8000, 1'b1}
    };

    logic        clk = 0, rst_n = 0;
    logic        cfg_load = 0, cfg_blk_src = 0, cfg_word = 0, start = 0, irq_clr = 0;
    logic [15:0] cfg_src = 0, cfg_dst = 0, cfg_bcount = 0;
    logic [7:0]  cfg_bsize = 0;
    logic [1:0]  cfg_step_mode = 0;
    logic        mem_req, mem_we, mem_ready, busy, done, irq;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        stall_en = 0, stall_ph = 0;
    int          total = 0, bad = 0;

    function automatic logic [15:0] mem_val(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) stall_ph <= ~stall_ph;
    assign mem_ready = mem_req && !(stall_en && stall_ph);
    assign mem_rdata = mem_val(mem_addr);

    blk_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_bsize(cfg_bsize), .cfg_bcount(cfg_bcount),
        .cfg_blk_src(cfg_blk_src), .cfg_step_mode(cfg_step_mode), .cfg_word(cfg_word),
        .start(start), .irq_clr(irq_clr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input vec_t v);
        @(negedge clk);
        cfg_load = 1; cfg_blk_src = v.bsrc; cfg_step_mode = v.mode; cfg_word = v.word;
        cfg_bsize = v.bsz; cfg_bcount = v.bcnt; cfg_src = v.src; cfg_dst = v.dst;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    // checks every write of block b (R2, R3, R4, R5) and the end of block (R5, R7)
    task automatic check_block(input vec_t v, input int b, input bit last);
        logic [15:0] st, dlt, es, ed;
        int n;
        n   = (v.bsz == 0) ? 256 : int'(v.bsz);
        st  = v.word ? 16'd2 : 16'd1;
        dlt = (v.mode == 2'b01) ? st : (v.mode == 2'b10) ? (16'd0 - st) : 16'd0;
        for (int u = 0; u < n; u++) begin
            do begin @(negedge clk); #1; end
            while (!(mem_req && mem_we && mem_ready));
            if (v.bsrc) begin
                es = v.src + 16'(u) * st;
                ed = v.dst + 16'(b) * dlt;
            end else begin
                es = v.src + 16'(b) * dlt;
                ed = v.dst + 16'(u) * st;
            end
            chk(mem_addr == ed, "R3/R4", "write address", mem_addr, ed);
            chk(mem_wdata == mem_val(es), "R2", "write data", mem_wdata, mem_val(es));
        end
        @(negedge clk); #1;
        chk(done && !busy, "R5", "done pulse after block", {done, busy}, 2'b10);
        chk(irq == last, "R7", "irq at block end", irq, last);
        @(negedge clk); #1;
        chk(!done, "R5", "done lasts one cycle", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t v;
        int   nb;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req && !done && !irq, "R1", "reset state",
            {busy, mem_req, done, irq}, 0);
        rst_n = 1;

        // R9: start before any load
        pulse_start();
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req, "R9", "start before load ignored", busy, 0);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            stall_en = v.stall;
            do_load(v);
            nb = int'(v.bcnt);
            for (int b = 0; b < nb; b++) begin
                pulse_start();
                check_block(v, b, b == nb - 1);
            end
            repeat (2) @(negedge clk);
            #1;
            chk(irq, "R8", "irq held", irq, 1);
            pulse_start();
            repeat (3) @(negedge clk);
            #1;
            chk(!busy && !mem_req, "R9", "start after last block ignored", busy, 0);
            pulse_clr();
            #1;
            chk(!irq, "R8", "irq cleared", irq, 0);
        end

        // R6: start and load while busy are ignored
        stall_en = 1;
        v = '{1'b1, 2'b01, 1'b0, 8'd3, 16'd2, 16'h5000, 16'h6000, 1'b1};
        do_load(v);
        pulse_start();
        cfg_load = 1; start = 1; cfg_src = 16'h7777; cfg_dst = 16'h1111;
        cfg_bsize = 8'd9; cfg_bcount = 16'd1;
        @(negedge clk);
        cfg_load = 0; start = 0;
        check_block(v, 0, 1'b0);
        chk(!irq, "R6", "busy start did not count a block", irq, 0);
        pulse_start();
        check_block(v, 1, 1'b1);
        pulse_clr();

        // R7: count 0 encodes 65536 blocks, so no irq after a few blocks
        stall_en = 0;
        v = '{1'b0, 2'b10, 1'b1, 8'd1, 16'd0, 16'h0400, 16'h0500, 1'b0};
        do_load(v);
        for (int b = 0; b < 3; b++) begin
            pulse_start();
            check_block(v, b, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule